// File: doc/BRIEF.md
# Auto-addressed key store

The block holds cipher keys in a 32-word by 32-bit memory and fills it from a DMA word stream that carries no address. Software first writes a load setup that names a starting key area and a key size. The block then works out every write address by itself, starting at the first word of the chosen area and stepping by one for each accepted word. The stream has no ready signal: the block takes a word on any cycle in which a load is open, and this works at the full rate of one word per cycle.

The memory is split into eight key areas of four words (128 bits) each. A 128-bit key fills one area. A 192-bit key covers two areas, and only the first two words of the second area are written. A 256-bit key fills two whole areas. For each area the block keeps a "loaded" flag that the cipher core can read next to the key. When a setup is accepted, the flags of the areas it will overwrite are cleared. A setup that does not fit the memory raises an error flag and opens no load. The cipher core reads keys through a separate synchronous read port. The DMA can never read from the store.

Top module: `keyslot_store`

## Requirements
- R1: After a synchronous active-low reset, `area_loaded` is 0, `cfg_error` is 0, `load_busy` is 0 and `rd_data` is 0.
- R2: A setup strobe (`cfg_valid`) with `cfg_size` code 0 selects 128 bits (4 words), code 1 selects 192 bits (6 words) and code 2 selects 256 bits (8 words). The k-th word accepted after the setup (k from 0) is written to address `cfg_area`*4+k.
- R3: While a load is open, a word is accepted on every cycle in which `wr_valid` is high, including back-to-back cycles. There are no wait states.
- R4: Once the word count of the key has been accepted, `load_busy` falls on the next clock edge. Any further words are dropped, and memory is left unchanged.
- R5: A word that arrives while no load is open changes neither the memory nor `area_loaded`.
- R6: The flag `area_loaded[i]` goes to 1 at the clock edge that writes the last word a load places in area i. That word is the fourth word of the area, or the final word of the key for the second area of a 192-bit key.
- R7: An accepted setup clears the `area_loaded` bits of every area it covers at the next edge. The bits of all other areas keep their values.
- R8: A setup is rejected if it uses code 3, if the key would run past area 7, or if a 256-bit key starts in an odd area. A rejected setup sets `cfg_error` and closes any open load, and it leaves memory and `area_loaded` unchanged. The next accepted setup clears `cfg_error`.
- R9: When `cfg_valid` and `wr_valid` are high in the same cycle, the setup takes effect and the word is dropped. Any load still open is abandoned, and the new load starts at its own base address.
- R10: `rd_data` shows the word at `rd_addr` one cycle after the address is presented. If that address is written in the same cycle, `rd_data` shows the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Load setup strobe |
| cfg_area | input | 3 | First key area of the load |
| cfg_size | input | 2 | Key size code: 0 = 128 bits, 1 = 192 bits, 2 = 256 bits, 3 = invalid |
| wr_valid | input | 1 | DMA word present |
| wr_data | input | 32 | DMA word |
| rd_addr | input | 5 | Cipher-side read word address |
| rd_data | output | 32 | Cipher-side read data, one cycle latency |
| area_loaded | output | 8 | One flag per key area: key fully written |
| cfg_error | output | 1 | Last rejected setup flag |
| load_busy | output | 1 | A load is open and accepting words |

## Verification
The hardest cases to reach are the collisions between a setup and the word stream. One is a setup that arrives in the same cycle as a word, partway through an unfinished load. The other is a 192-bit key whose second area must be marked loaded after only two words. The bench reaches both with hand-placed sequences: it starts a load, streams part of it, and then issues the next setup with `wr_valid` still high. It also runs 192-bit loads from several start areas, including area 6 (accepted) and area 7 (rejected), and streams words after each rejection. A behavioural model tracks memory, flags and the open load, and it is compared on every clock, so a word that is dropped or sent to the wrong address shows up in a later read-back.

// File: rtl/ks_pkg.sv
// Package: shared types and helpers for the key store.
// Assumes the data word is 32 bits or a divisor of 128.
package ks_pkg;

    typedef enum logic [1:0] {
        KSZ_128 = 2'd0,
        KSZ_192 = 2'd1,
        KSZ_256 = 2'd2,
        KSZ_BAD = 2'd3
    } ksize_e;

    // Number of words a key of the given size occupies; 0 for an invalid code.
    function automatic int key_words(ksize_e sz, int dw);
        case (sz)
            KSZ_128: key_words = 128 / dw;
            KSZ_192: key_words = 192 / dw;
            KSZ_256: key_words = 256 / dw;
            default: key_words = 0;
        endcase
    endfunction

endpackage

// File: rtl/ks_cfg_check.sv
// Module: ks_cfg_check
// Decodes a load setup into a word count and an area span, and decides
// whether the setup fits the store. Purely combinational.
// Assumes AREA_WORDS is a power of two.
module ks_cfg_check
    import ks_pkg::*;
#(
    parameter int N_AREAS    = 8,
    parameter int AREA_WORDS = 4,
    parameter int DATA_W     = 32,
    localparam int AREA_W    = $clog2(N_AREAS),
    localparam int CNT_W     = $clog2(256 / DATA_W + 1)
) (
    input  logic [AREA_W-1:0] area,
    input  ksize_e            size,
    output logic              ok,
    output logic [CNT_W-1:0]  n_words,
    output logic [AREA_W:0]   n_areas
);

    // Range and alignment decision for the requested setup.
    always_comb begin
        int w;
        int a;
        int start;
        w     = key_words(size, DATA_W);
        a     = (w + AREA_WORDS - 1) / AREA_WORDS;
        start = int'(area);
        n_words = CNT_W'(w);
        n_areas = (AREA_W + 1)'(a);
        ok = (size != KSZ_BAD) && (w > 0) && (start + a <= N_AREAS);
        if (size == KSZ_256 && a > 0 && (start % a) != 0)
            ok = 1'b0;
    end

endmodule

// File: rtl/ks_addr_gen.sv
// Module: ks_addr_gen
// Holds the open load: the running write address and the words left.
// It opens a load on an accepted setup and closes it on a rejected setup
// or after the last word. A setup in the same cycle as a word wins.
module ks_addr_gen #(
    parameter int N_AREAS    = 8,
    parameter int AREA_WORDS = 4,
    parameter int DATA_W     = 32,
    localparam int AREA_W    = $clog2(N_AREAS),
    localparam int ADDR_W    = $clog2(N_AREAS * AREA_WORDS),
    localparam int CNT_W     = $clog2(256 / DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_ok,
    input  logic [AREA_W-1:0] base_area,
    input  logic [CNT_W-1:0]  n_words,
    input  logic              wr_valid,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              last_word,
    output logic              active
);

    logic [CNT_W-1:0] remain;

    // Accept a word only while a load is open and no setup competes.
    assign we        = wr_valid && active && !cfg_req;
    assign last_word = (remain == CNT_W'(1));

    // Address and remaining-count bookkeeping for the open load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            waddr  <= '0;
            remain <= '0;
        end else if (cfg_req) begin
            active <= cfg_ok;
            if (cfg_ok) begin
                waddr  <= ADDR_W'(base_area) * ADDR_W'(AREA_WORDS);
                remain <= n_words;
            end
        end else if (we) begin
            waddr  <= waddr + 1'b1;
            remain <= remain - 1'b1;
            if (last_word)
                active <= 1'b0;
        end
    end

    // R2: every accepted non-final word moves the address by one.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !last_word) |=> (waddr == $past(waddr) + 1'b1));

    // R4: the final word closes the load.
    assert_last_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && last_word) |=> !active);

endmodule

// File: rtl/ks_status.sv
// Module: ks_status
// Keeps one loaded flag per key area and the setup error flag.
// An accepted setup clears the flags of the areas it covers; a write of
// an area's final word sets its flag. Assumes AREA_WORDS is a power of two.
module ks_status #(
    parameter int N_AREAS    = 8,
    parameter int AREA_WORDS = 4,
    localparam int AREA_W    = $clog2(N_AREAS),
    localparam int OFF_W     = $clog2(AREA_WORDS),
    localparam int ADDR_W    = $clog2(N_AREAS * AREA_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_req,
    input  logic               cfg_ok,
    input  logic [AREA_W-1:0]  base_area,
    input  logic [AREA_W:0]    n_areas,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic               last_word,
    output logic [N_AREAS-1:0] loaded,
    output logic               err
);

    logic [N_AREAS-1:0] clr_mask;
    logic [N_AREAS-1:0] set_mask;
    logic [AREA_W-1:0]  w_area;
    logic [OFF_W-1:0]   w_off;

    assign w_area = waddr[ADDR_W-1:OFF_W];
    assign w_off  = waddr[OFF_W-1:0];

    // One clear and one set term per area.
    for (genvar i = 0; i < N_AREAS; i++) begin : g_area
        assign clr_mask[i] = cfg_req && cfg_ok &&
                             ((AREA_W + 1)'(i) >= {1'b0, base_area}) &&
                             ((AREA_W + 1)'(i) < ({1'b0, base_area} + n_areas));
        assign set_mask[i] = we && (w_area == AREA_W'(i)) &&
                             ((w_off == OFF_W'(AREA_WORDS - 1)) || last_word);
    end

    // Flag register update: clear on accepted setup, set on final area word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            loaded <= '0;
        else
            loaded <= (loaded & ~clr_mask) | set_mask;
    end

    // Error flag: raised by a rejected setup, dropped by an accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (cfg_req)
            err <= !cfg_ok;
    end

    // R5: with no setup and no accepted word the flags hold.
    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !cfg_req) |=> ($stable(loaded) && $stable(err)));

    // R8: a rejected setup leaves the area flags as they were.
    assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ok) |=> (err && $stable(loaded)));

endmodule

// File: rtl/ks_mem.sv
// Module: ks_mem
// Key storage with one write port and one registered read port.
// A read of the address being written returns the previous contents.
module ks_mem #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    // Write port: storage has no reset.
    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    // Read port: one cycle latency, old data on collision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/keyslot_store.sv
// Module: keyslot_store (top)
// Key store filled by an address-less DMA word stream. A setup picks the
// first area and key size; the block generates write addresses itself,
// tracks per-area loaded flags and flags setups that do not fit.
module keyslot_store (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_valid,
    input  logic [2:0]  cfg_area,
    input  logic [1:0]  cfg_size,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic [4:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [7:0]  area_loaded,
    output logic        cfg_error,
    output logic        load_busy
);
    import ks_pkg::*;

    localparam int N_AREAS    = 8;
    localparam int AREA_WORDS = 4;
    localparam int DATA_W     = 32;
    localparam int DEPTH      = N_AREAS * AREA_WORDS;
    localparam int AREA_W     = $clog2(N_AREAS);
    localparam int ADDR_W     = $clog2(DEPTH);
    localparam int CNT_W      = $clog2(256 / DATA_W + 1);

    logic              cfg_ok;
    logic [CNT_W-1:0]  n_words;
    logic [AREA_W:0]   n_areas;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic              last_word;

    ks_cfg_check #(.N_AREAS(N_AREAS), .AREA_WORDS(AREA_WORDS), .DATA_W(DATA_W)) u_check (
        .area    (cfg_area),
        .size    (ksize_e'(cfg_size)),
        .ok      (cfg_ok),
        .n_words (n_words),
        .n_areas (n_areas)
    );

    ks_addr_gen #(.N_AREAS(N_AREAS), .AREA_WORDS(AREA_WORDS), .DATA_W(DATA_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_req   (cfg_valid),
        .cfg_ok    (cfg_ok),
        .base_area (cfg_area),
        .n_words   (n_words),
        .wr_valid  (wr_valid),
        .we        (we),
        .waddr     (waddr),
        .last_word (last_word),
        .active    (load_busy)
    );

    ks_status #(.N_AREAS(N_AREAS), .AREA_WORDS(AREA_WORDS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_req   (cfg_valid),
        .cfg_ok    (cfg_ok),
        .base_area (cfg_area),
        .n_areas   (n_areas),
        .we        (we),
        .waddr     (waddr),
        .last_word (last_word),
        .loaded    (area_loaded),
        .err       (cfg_error)
    );

    ks_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R9: a setup in the same cycle as a word blocks that write.
    assert_cfg_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !we);

endmodule

// File: tb/keyslot_store_tb.sv
// Bench: behavioural model of the key store compared on every clock.
module keyslot_store_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_area = '0;
    logic [1:0]  cfg_size = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  area_loaded;
    logic        cfg_error;
    logic        load_busy;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    // Reference model state.
    logic [31:0] m_mem [32];
    logic [7:0]  m_loaded;
    logic        m_err;
    logic        m_active;
    int          m_addr;
    int          m_rem;
    logic [31:0] m_rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyslot_store dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_area(cfg_area),
        .cfg_size(cfg_size), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .area_loaded(area_loaded),
        .cfg_error(cfg_error), .load_busy(load_busy)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at each rising edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_loaded = '0; m_err = 1'b0; m_active = 1'b0;
            m_addr = 0; m_rem = 0; m_rd = '0;
        end else begin
            m_rd = m_mem[rd_addr];
            if (cfg_valid) begin
                int w;
                int a;
                bit ok;
                w  = (cfg_size == 2'd0) ? 4 : (cfg_size == 2'd1) ? 6 : (cfg_size == 2'd2) ? 8 : 0;
                a  = (w + 3) / 4;
                ok = (w != 0) && (int'(cfg_area) + a <= 8) &&
                     !(cfg_size == 2'd2 && cfg_area[0]);
                if (ok) begin
                    for (int i = 0; i < a; i++) m_loaded[int'(cfg_area) + i] = 1'b0;
                    m_addr = int'(cfg_area) * 4; m_rem = w; m_active = 1'b1; m_err = 1'b0;
                end else begin
                    m_err = 1'b1; m_active = 1'b0;
                end
            end else if (wr_valid && m_active) begin
                m_mem[m_addr] = wr_data;
                if ((m_addr % 4) == 3 || m_rem == 1) m_loaded[m_addr / 4] = 1'b1;
                m_addr++; m_rem--;
                if (m_rem == 0) m_active = 1'b0;
            end
        end
    end

    // Compare all outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (model_on) begin
            check("R6/R7 area_loaded", 32'(area_loaded), 32'(m_loaded));
            check("R8 cfg_error", 32'(cfg_error), 32'(m_err));
            check("R4 load_busy", 32'(load_busy), 32'(m_active));
            check("R10/R2 rd_data", rd_data, m_rd);
        end
    end

    task automatic idle(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_valid = 1'b0; wr_valid = 1'b0;
        end
    endtask

    task automatic setup(logic [2:0] area, logic [1:0] size, bit with_word = 0, logic [31:0] d = '0);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_area = area; cfg_size = size;
        wr_valid = with_word; wr_data = d;
    endtask

    task automatic words(int n, logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_valid = 1'b0; wr_valid = 1'b1; wr_data = seed + 32'(i);
            rd_addr = rd_addr + 5'd3;
        end
    endtask

    task automatic read_all();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            cfg_valid = 1'b0; wr_valid = 1'b0; rd_addr = 5'(i);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 32'hDEAD_0000 + 32'(i);
        // Fill storage with known values through the normal port first.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a += 2) begin
            setup(3'(a), 2'd2);
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                cfg_valid = 1'b0; wr_valid = 1'b1; wr_data = 32'hDEAD_0000 + 32'(a * 4 + i);
            end
        end
        idle(1);
        rst_n = 1'b0;
        idle(2);
        model_on = 1'b1;
        #3;
        // R1: reset values.
        check("R1 area_loaded", 32'(area_loaded), 32'h0);
        check("R1 cfg_error", 32'(cfg_error), 32'h0);
        check("R1 load_busy", 32'(load_busy), 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        // R5: words with no load open are dropped.
        words(3, 32'h5555_0000); idle(1);
        // R2/R3/R4: 128-bit key in area 0, back-to-back, then extra words dropped.
        setup(3'd0, 2'd0); words(6, 32'hA000_0000); idle(2);
        // R6: 192-bit key in area 2 with a gap.
        setup(3'd2, 2'd1); words(3, 32'hB000_0000); idle(1); words(3, 32'hB000_0010); idle(1);
        // 256-bit key in area 4.
        setup(3'd4, 2'd2); words(8, 32'hC000_0000); idle(1);
        // R8: rejected setups, each followed by words.
        setup(3'd7, 2'd1); words(2, 32'hE000_0000);
        setup(3'd3, 2'd2); words(2, 32'hE100_0000);
        setup(3'd1, 2'd3); words(2, 32'hE200_0000);
        setup(3'd7, 2'd2); words(2, 32'hE300_0000); idle(1);
        // 192-bit key at the top edge (area 6) is accepted.
        setup(3'd6, 2'd1); words(6, 32'hF000_0000); idle(1);
        // R9: setup collides with a word partway through a load.
        setup(3'd1, 2'd0); words(2, 32'h9000_0000);
        setup(3'd5, 2'd0, 1'b1, 32'h9999_9999); words(4, 32'h9100_0000); idle(1);
        // R7: reselecting area 0 clears only its flag; load left unfinished.
        setup(3'd0, 2'd0); words(2, 32'h8000_0000); idle(2);
        // R10: read of address being written returns old word.
        @(negedge clk); rd_addr = 5'd2; cfg_valid = 1'b0; wr_valid = 1'b1; wr_data = 32'h7777_7777;
        @(negedge clk); wr_valid = 1'b0;
        idle(1);
        read_all(); idle(2);

        // Directed end checks on expected final flag pattern (R6, R7).
        // area0 open, 1 cleared then abandoned, 2/3 from 192, 4 cleared by collision? no: 5 reloaded.
        check("R6 area2 loaded", 32'(area_loaded[2]), 32'h1);
        check("R6 area3 loaded 192 tail", 32'(area_loaded[3]), 32'h1);
        check("R7 area0 cleared", 32'(area_loaded[0]), 32'h0);
        check("R9 area1 abandoned", 32'(area_loaded[1]), 32'h0);
        check("R9 area5 loaded", 32'(area_loaded[5]), 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule